// File: doc/BRIEF.md
# Post-Reset Self-Test and Initialization Sequencer

This block decides what a processor core does between the release of its reset pin and its first bus cycle. While `reset_in` is high it holds every status output low, keeps the internal two-phase clock phase at a known value, and watches `busy_n` to learn whether a built-in self-test was requested. Once reset is released it can run a self-test window of fixed length, and it then always runs an initialization window. During the later part of initialization it watches `err_n` to find out whether an advanced numeric coprocessor is attached. When initialization ends it pulses `first_bus_ready` for one cycle.

The self-test logic itself is not part of this block. Its pass/fail outcome arrives as the signature `selftest_sig`, which is compared against the parameter `SIG_GOOD`. A mismatch is recorded in `selftest_fail`, but it never changes the length of the sequence and never stops it. The block can only tell an advanced coprocessor from "older type or none". Telling an older coprocessor apart from no coprocessor is left to software.

The block has only plain control and status pins, with no data stream and no handshake. Call the first cycle in which `reset_in` is sampled low cycle 0. If a self-test runs, it occupies cycles 1 to `BIST_LEN`. Initialization occupies the `INIT_LEN` cycles that follow. `INIT_LEN` defaults to 400. `BIST_LEN` defaults to 2^20+60 and can be shortened for simulation.

Top module: `reset_init_sequencer`

## Requirements
- R1: In the cycle after any clock edge that samples `reset_in` high, `bist_active`, `init_active`, `first_bus_ready`, `copro_adv`, `selftest_fail` and `clk_phase` are all 0. They stay 0 until cycle 0 ends.
- R2: `clk_phase` is 0 in cycle 0 and inverts on every following cycle while reset stays low, so it equals the cycle number modulo 2.
- R3: If `busy_n` is 0 at the last edge that samples `reset_in` high, `bist_active` is 1 in exactly cycles 1 to `BIST_LEN`. Otherwise it is never 1.
- R4: `init_active` is 1 for exactly `INIT_LEN` cycles. These start in cycle `BIST_LEN`+1 when a self-test ran, and in cycle 1 when it did not.
- R5: The self-test window length and the start of initialization do not depend on `selftest_sig`. A failing signature still leads into initialization.
- R6: `selftest_fail` becomes 1 in the cycle after the last self-test cycle if `selftest_sig` differs from `SIG_GOOD` at that cycle's closing edge. Otherwise it stays 0. It then holds its value until reset, and it stays 0 when no self-test ran.
- R7: `copro_adv` becomes 1 in the cycle after any edge where `err_n` is 0 during initialization cycle index `ERR_FROM` or later. The index of the first initialization cycle is 0. `err_n` low before that index, or outside initialization, has no effect. Once set, `copro_adv` holds its value until reset.
- R8: `first_bus_ready` is 1 for exactly one cycle, the cycle right after the last initialization cycle. It does not pulse again before the next reset.
- R9: Asserting `reset_in` during either window ends that window. Both active flags are 0 in the next cycle, and the whole sequence restarts after the next release.
- R10: `bist_active` and `init_active` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every register updates on its rising edge |
| reset_in | input | 1 | Synchronous active-high reset; the falling edge starts the sequence |
| busy_n | input | 1 | Low while reset is held to request the self-test |
| err_n | input | 1 | Error line; low during the detection window marks an advanced coprocessor |
| selftest_sig | input | SIG_W | Outcome signature produced by the self-test logic |
| clk_phase | output | 1 | Internal two-phase clock phase |
| bist_active | output | 1 | High during the self-test window |
| init_active | output | 1 | High during the initialization window |
| copro_adv | output | 1 | Advanced coprocessor detected |
| selftest_fail | output | 1 | Latched self-test failure |
| first_bus_ready | output | 1 | One-cycle pulse allowing the first bus cycle |

## Verification
Most internal faults show up at the ports within one or two cycles of the point where they occur. A window counter that is off by one moves the falling edge of `bist_active` or `init_active`, and it moves the `first_bus_ready` pulse by the same number of cycles. A corrupted state register shows up at once as both flags high, or as a window that never ends. A wrong detection threshold only appears at the exact boundary indexes `ERR_FROM`-1 and `ERR_FROM`, so the bench pulses `err_n` for a single cycle at those indexes and at the last initialization cycle and the ready cycle. It then compares `copro_adv` one cycle later. Abort faults appear in the cycle after reset is raised in the middle of a window.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [1:0] {
    SQ_HOLD = 2'd0,
    SQ_BIST = 2'd1,
    SQ_INIT = 2'd2,
    SQ_RUN  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/rst_phase_gen.sv
module rst_phase_gen (
  input  logic clk,
  input  logic reset_in,
  output logic phase_o
);
  // Held at 0 in reset so that the first released cycle is phase 0.
  always_ff @(posedge clk) begin
    if (reset_in) phase_o <= 1'b0;
    else          phase_o <= ~phase_o;
  end
endmodule

// File: rtl/rst_win_counter.sv
module rst_win_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (clr) cnt_o <= '0;
    else     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rst_copro_detect.sv
module rst_copro_detect #(
  parameter int W        = 8,
  parameter int ERR_FROM = 20
) (
  input  logic         clk,
  input  logic         reset_in,
  input  logic         in_init,
  input  logic [W-1:0] idx,
  input  logic         err_n,
  output logic         adv_o
);
  localparam logic [W-1:0] FROM_V = W'(ERR_FROM);

  logic in_window;
  assign in_window = in_init && (idx >= FROM_V);

  // Sticky: one low sample inside the window is enough.
  always_ff @(posedge clk) begin
    if (reset_in)                adv_o <= 1'b0;
    else if (in_window && !err_n) adv_o <= 1'b1;
  end
endmodule

// File: rtl/reset_init_sequencer.sv
module reset_init_sequencer
  import rst_seq_pkg::*;
#(
  parameter int              BIST_LEN = (1 << 20) + 60,
  parameter int              INIT_LEN = 400,
  parameter int              ERR_FROM = 20,
  parameter int              SIG_W    = 8,
  parameter logic [SIG_W-1:0] SIG_GOOD = 8'hA5
) (
  input  logic             clk,
  input  logic             reset_in,
  input  logic             busy_n,
  input  logic             err_n,
  input  logic [SIG_W-1:0] selftest_sig,
  output logic             clk_phase,
  output logic             bist_active,
  output logic             init_active,
  output logic             copro_adv,
  output logic             selftest_fail,
  output logic             first_bus_ready
);
  localparam int            MAXLEN    = (BIST_LEN > INIT_LEN) ? BIST_LEN : INIT_LEN;
  localparam int            CW        = $clog2(MAXLEN + 1);
  localparam logic [CW-1:0] BIST_LAST = CW'(BIST_LEN - 1);
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_LEN - 1);

  sq_state_e     state_q;
  logic          want_bist_q;
  logic          fail_q;
  logic          rdy_q;
  logic [CW-1:0] cnt;
  logic          bist_last, init_last, cnt_clr;

  assign bist_last = (state_q == SQ_BIST) && (cnt == BIST_LAST);
  assign init_last = (state_q == SQ_INIT) && (cnt == INIT_LAST);
  assign cnt_clr   = reset_in || (state_q == SQ_HOLD) || (state_q == SQ_RUN)
                     || bist_last || init_last;

  rst_phase_gen u_phase (
    .clk      (clk),
    .reset_in (reset_in),
    .phase_o  (clk_phase)
  );

  rst_win_counter #(.W(CW)) u_cnt (
    .clk   (clk),
    .clr   (cnt_clr),
    .cnt_o (cnt)
  );

  rst_copro_detect #(.W(CW), .ERR_FROM(ERR_FROM)) u_copro (
    .clk      (clk),
    .reset_in (reset_in),
    .in_init  (state_q == SQ_INIT),
    .idx      (cnt),
    .err_n    (err_n),
    .adv_o    (copro_adv)
  );

  // The self-test request is re-sampled on every reset edge, so the last one counts.
  always_ff @(posedge clk) begin
    if (reset_in) begin
      state_q     <= SQ_HOLD;
      want_bist_q <= ~busy_n;
      fail_q      <= 1'b0;
      rdy_q       <= 1'b0;
    end else begin
      rdy_q <= 1'b0;
      case (state_q)
        SQ_HOLD: state_q <= want_bist_q ? SQ_BIST : SQ_INIT;
        SQ_BIST: if (bist_last) begin
          state_q <= SQ_INIT;
          fail_q  <= (selftest_sig != SIG_GOOD);
        end
        SQ_INIT: if (init_last) begin
          state_q <= SQ_RUN;
          rdy_q   <= 1'b1;
        end
        SQ_RUN:  state_q <= SQ_RUN;
      endcase
    end
  end

  assign bist_active     = (state_q == SQ_BIST);
  assign init_active     = (state_q == SQ_INIT);
  assign selftest_fail   = fail_q;
  assign first_bus_ready = rdy_q;
endmodule

// File: rtl/reset_init_sequencer_chk.sv
module reset_init_sequencer_chk #(
  parameter int BIST_LEN = 16
) (
  input logic clk,
  input logic reset_in,
  input logic clk_phase,
  input logic bist_active,
  input logic init_active,
  input logic copro_adv,
  input logic selftest_fail,
  input logic first_bus_ready
);
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (reset_in || !bist_active) run_q <= '0;
    else                          run_q <= run_q + 32'd1;
  end

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    reset_in |=> (!bist_active && !init_active && !first_bus_ready &&
                  !copro_adv && !selftest_fail && !clk_phase)); // R1

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (reset_in)
    !$past(reset_in) |-> (clk_phase != $past(clk_phase))); // R2

  AST_BIST_LENGTH: assert property (@(posedge clk) disable iff (reset_in)
    ($fell(bist_active) && !$past(reset_in)) |-> (run_q == 32'(BIST_LEN))); // R3

  AST_READY_FOLLOWS_INIT: assert property (@(posedge clk) disable iff (reset_in)
    $rose(first_bus_ready) |-> $past(init_active)); // R4

  AST_INIT_AFTER_BIST: assert property (@(posedge clk) disable iff (reset_in)
    ($fell(bist_active) && !$past(reset_in)) |-> init_active); // R5

  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (reset_in)
    (!bist_active && !$past(reset_in)) |=> $stable(selftest_fail)); // R6

  AST_COPRO_STICKY: assert property (@(posedge clk) disable iff (reset_in)
    copro_adv |=> copro_adv); // R7

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (reset_in)
    first_bus_ready |=> !first_bus_ready); // R8

  AST_ABORT_CLEARS: assert property (@(posedge clk)
    $rose(reset_in) |=> (!bist_active && !init_active)); // R9

  AST_WINDOWS_EXCLUSIVE: assert property (@(posedge clk) disable iff (reset_in)
    !(bist_active && init_active)); // R10
endmodule

bind reset_init_sequencer reset_init_sequencer_chk #(.BIST_LEN(BIST_LEN)) u_chk (
  .clk             (clk),
  .reset_in        (reset_in),
  .clk_phase       (clk_phase),
  .bist_active     (bist_active),
  .init_active     (init_active),
  .copro_adv       (copro_adv),
  .selftest_fail   (selftest_fail),
  .first_bus_ready (first_bus_ready)
);

// File: tb/tb_reset_init_sequencer.sv
`timescale 1ns/1ps
module tb_reset_init_sequencer;
  localparam int         BL   = 30;
  localparam int         IL   = 40;
  localparam int         EF   = 20;
  localparam logic [7:0] GOOD = 8'hA5;
  localparam int         NONE = 100000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       reset_in = 1'b1, busy_n = 1'b1, err_n = 1'b1;
  logic [7:0] sig = GOOD;
  logic       clk_phase, bist_active, init_active, copro_adv, selftest_fail, first_bus_ready;

  reset_init_sequencer #(.BIST_LEN(BL), .INIT_LEN(IL), .ERR_FROM(EF),
                         .SIG_W(8), .SIG_GOOD(GOOD)) dut (
    .clk(clk), .reset_in(reset_in), .busy_n(busy_n), .err_n(err_n),
    .selftest_sig(sig), .clk_phase(clk_phase), .bist_active(bist_active),
    .init_active(init_active), .copro_adv(copro_adv),
    .selftest_fail(selftest_fail), .first_bus_ready(first_bus_ready));

  int checks = 0, fails = 0;
  int rel = 0;
  bit req = 0, m_copro = 0, m_fail = 0, armed = 0;

  // Behavioural reference: cycle index since release plus two sticky flags.
  always @(posedge clk) begin
    int s;
    s = 1 + (req ? BL : 0);
    armed = 1;
    if (reset_in) begin
      rel = 0; req = !busy_n; m_copro = 0; m_fail = 0;
    end else begin
      if (req && rel == BL) m_fail = (sig != GOOD);
      if (rel >= s + EF && rel < s + IL && !err_n) m_copro = 1;
      rel++;
    end
  end

  task automatic cmp(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b rel=%0d t=%0t", tag, name, act, exp, rel, $time);
    end
  endtask

  always @(negedge clk) if (armed) begin
    int s;
    bit r0;
    s  = 1 + (req ? BL : 0);
    r0 = (rel == 0);
    cmp(r0 ? "R1" : "R2", "clk_phase", clk_phase, 1'(rel % 2));
    cmp(r0 ? "R1" : "R3 R9", "bist_active", bist_active, req && rel >= 1 && rel <= BL);
    cmp(r0 ? "R1" : "R4 R5 R9", "init_active", init_active, rel >= s && rel < s + IL);
    cmp(r0 ? "R1" : "R8", "first_bus_ready", first_bus_ready, rel == s + IL);
    cmp(r0 ? "R1" : "R7", "copro_adv", copro_adv, m_copro);
    cmp(r0 ? "R1" : "R6", "selftest_fail", selftest_fail, m_fail);
    cmp("R10", "both_windows", bist_active && init_active, 1'b0);
  end

  task automatic scen(bit b, logic [7:0] sg, int lo_from, int lo_to, int abort_at, int n);
    int ab;
    ab = abort_at;
    @(negedge clk);
    reset_in = 1; busy_n = b; sig = sg; err_n = 1;
    repeat (3) @(negedge clk);
    reset_in = 0;
    for (int k = 0; k < n; k++) begin
      int s;
      @(negedge clk);
      s = 1 + (req ? BL : 0);
      if (ab >= 0 && rel == ab) begin
        reset_in = 1;                 // R9 abort in the middle of a window
        err_n = 1;
        repeat (2) @(negedge clk);
        reset_in = 0;
        ab = -1;
      end else begin
        err_n = !((rel - s) >= lo_from && (rel - s) <= lo_to);
      end
    end
    err_n = 1;
  endtask

  initial begin
    scen(1, GOOD, NONE, NONE, -1, 60);      // R4 R8 no self-test
    scen(0, GOOD, 5, 10, -1, 90);           // R3 R7 err low before window: no effect
    scen(0, 8'h3C, 25, 30, -1, 90);         // R5 R6 failing signature, R7 detection
    scen(0, 8'h00, NONE, NONE, 10, 100);    // R9 abort during self-test
    scen(1, GOOD, NONE, NONE, 15, 70);      // R9 abort during init
    scen(1, GOOD, EF, EF, -1, 60);          // R7 first window index counts
    scen(1, GOOD, EF - 1, EF - 1, -1, 60);  // R7 one index early is ignored
    scen(1, GOOD, IL - 1, IL - 1, -1, 60);  // R7 last init cycle counts
    scen(1, GOOD, IL, IL, -1, 60);          // R7 ready cycle is ignored
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule